// File: doc/BRIEF.md
# Interrupt Status, Mask and Acknowledge Unit

This unit collects interrupt causes for a packet-oriented network controller into an 8-bit status vector. It gates that vector with an 8-bit enable mask and drives one level-sensitive interrupt line. The packet memory unit beside it sends one-cycle event pulses: allocation requested, allocation done, receive frame queued, receive queue emptied, and four auxiliary causes. It also supplies the live occupancy of its transmit queue and of its transmit-completion queue.

Two status bits are not plain sticky flags. They are recomputed from those occupancies on every clock. The transmit-queue-empty bit is set whenever the transmit queue holds nothing. The transmit-done bit is set while the completion queue still holds an entry after any pop made in the same cycle.

Software uses a byte-wide register port with one address bit. Address 0 reads the status vector, and a write to address 0 is an acknowledge. Address 1 reads and writes the mask. An acknowledge clears only the clearable bits that it names. When it names the transmit-done bit, it also sends a pop strobe to the completion queue, provided that queue is not empty.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status reads 0x04 (only bit 2, transmit queue empty), the mask reads 0x00 and `irq` is low.
- R2: `irq` is high exactly when status AND mask is non-zero. A mask write is reflected in `irq` in the same cycle as the new mask value is readable.
- R3: An acknowledge write (`reg_we`=1, `reg_addr`=0) clears the status bits given by `reg_wdata` AND 0xD6. Bits 0 (receive), 3 (allocation done) and 5 (PHY event) are never cleared by it.
- R4: `done_pop` is high in the cycle of an acknowledge write with `reg_wdata` bit 1 set and `done_count` non-zero. It is low in every other cycle.
- R5: In every clock cycle where `tx_count` is zero, status bit 2 is set at the next edge.
- R6: Status bit 1 (transmit done) is set at the next edge when `done_count` minus that cycle's `done_pop` is non-zero. An acknowledge that pops the last entry therefore clears it.
- R7: `ev_rx_queued` sets status bit 0 and `ev_rx_emptied` clears it. When both occur in the same cycle, the bit is set.
- R8: `ev_alloc_done` sets status bit 3 and `ev_alloc_req` clears it. When both occur in the same cycle, the bit is set.
- R9: Bit i of `ev_aux` sets status bit 4+i (bit 4 receive overrun, bit 5 PHY event, bit 6 early receive, bit 7 management).
- R10: When a set cause and an acknowledge clear hit the same status bit in the same cycle, the bit ends up set.
- R11: `reg_rdata` shows the registered status when `reg_addr` is 0 and the registered mask when `reg_addr` is 1. It changes with the address without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: status / acknowledge, 1: mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| ev_alloc_req | input | 1 | Allocation requested; clears bit 3 |
| ev_alloc_done | input | 1 | Allocation granted; sets bit 3 |
| ev_rx_queued | input | 1 | Receive frame queued; sets bit 0 |
| ev_rx_emptied | input | 1 | Receive queue popped to empty; clears bit 0 |
| ev_aux | input | 4 | Set pulses for status bits 7..4 |
| tx_count | input | CNT_W | Transmit queue occupancy |
| done_count | input | CNT_W | Transmit-completion queue occupancy |
| done_pop | output | 1 | Pop strobe to the completion queue |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions collide at the transmit-done bit. An acknowledge of bit 1 pops the completion queue and clears the bit, while the occupancy rule re-sets it in the same cycle. The bench provokes this with the queue holding two entries and then one, and expects the bit to survive the first acknowledge and to drop on the second. The same contest, set against clear, is provoked for the transmit-empty bit, the receive bit and the allocation bit by giving both causes in one cycle. In each case a behavioural model, updated on every clock, decides the outcome from the set-wins rule.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int STAT_W = 8;

    localparam int B_RX      = 0;
    localparam int B_TXDONE  = 1;
    localparam int B_TXEMPTY = 2;
    localparam int B_ALLOC   = 3;
    localparam int B_AUX0    = 4;
    localparam int AUX_W     = STAT_W - B_AUX0;

    localparam logic [STAT_W-1:0] ACK_CLEARABLE = 8'hD6;
    localparam logic [STAT_W-1:0] STATUS_RESET  = 8'h04;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] mask;
        logic              irq;
    } irq_state_t;

endpackage

// File: rtl/irq_port_decode.sv
module irq_port_decode
    import irq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  done_count,
    output logic [STAT_W-1:0] ack_clr,
    output logic              mask_we,
    output logic              pop
);
    logic ack_we;

    always_comb begin
        ack_we  = reg_we && (reg_addr == 1'b0);
        mask_we = reg_we && (reg_addr == 1'b1);
        ack_clr = ack_we ? (reg_wdata & ACK_CLEARABLE) : '0;
        pop     = ack_we && reg_wdata[B_TXDONE] && (done_count != '0);
    end

endmodule

// File: rtl/irq_status_next.sv
module irq_status_next
    import irq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [STAT_W-1:0] status_q,
    input  logic [STAT_W-1:0] ack_clr,
    input  logic              ev_alloc_req,
    input  logic              ev_alloc_done,
    input  logic              ev_rx_queued,
    input  logic              ev_rx_emptied,
    input  logic [AUX_W-1:0]  ev_aux,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  done_count,
    input  logic              pop,
    output logic [STAT_W-1:0] status_d
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [CNT_W-1:0]  pop_ext;
    logic              done_left;

    always_comb begin
        pop_ext   = {{(CNT_W-1){1'b0}}, pop};
        done_left = done_count > pop_ext;

        set_vec            = '0;
        set_vec[B_RX]      = ev_rx_queued;
        set_vec[B_TXDONE]  = done_left;
        set_vec[B_TXEMPTY] = (tx_count == '0);
        set_vec[B_ALLOC]   = ev_alloc_done;
        set_vec[STAT_W-1:B_AUX0] = ev_aux;

        clr_vec          = ack_clr;
        clr_vec[B_RX]    = ev_rx_emptied;
        clr_vec[B_ALLOC] = ev_alloc_req;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        assign status_d[i] = set_vec[i] | (status_q[i] & ~clr_vec[i]);
    end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ev_alloc_req,
    input  logic              ev_alloc_done,
    input  logic              ev_rx_queued,
    input  logic              ev_rx_emptied,
    input  logic [3:0]        ev_aux,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  done_count,
    output logic              done_pop,
    output logic              irq
);
    irq_state_t        st_d, st_q;
    logic [STAT_W-1:0] ack_clr;
    logic [STAT_W-1:0] status_nx;
    logic              mask_we;
    logic              pop;

    irq_port_decode #(.CNT_W(CNT_W)) u_decode (
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .done_count (done_count),
        .ack_clr    (ack_clr),
        .mask_we    (mask_we),
        .pop        (pop)
    );

    irq_status_next #(.CNT_W(CNT_W)) u_next (
        .status_q      (st_q.status),
        .ack_clr       (ack_clr),
        .ev_alloc_req  (ev_alloc_req),
        .ev_alloc_done (ev_alloc_done),
        .ev_rx_queued  (ev_rx_queued),
        .ev_rx_emptied (ev_rx_emptied),
        .ev_aux        (ev_aux),
        .tx_count      (tx_count),
        .done_count    (done_count),
        .pop           (pop),
        .status_d      (status_nx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.status = status_nx;
        if (mask_we) begin
            st_d.mask = reg_wdata;
        end
        st_d.irq = |(st_d.status & st_d.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.status <= STATUS_RESET;
            st_q.mask   <= '0;
            st_q.irq    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = reg_addr ? st_q.mask : st_q.status;
    assign done_pop  = pop;
    assign irq       = st_q.irq;

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             ev_alloc_req,
    input logic             ev_alloc_done,
    input logic             ev_rx_queued,
    input logic             ev_rx_emptied,
    input logic [3:0]       ev_aux,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] done_count,
    input logic             done_pop,
    input logic             irq,
    input logic [7:0]       stat_q,
    input logic [7:0]       msk_q
);
    // R2
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(stat_q & msk_q));

    // R4
    pop_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pop |-> (done_count != '0) && reg_we && !reg_addr && reg_wdata[1]);

    // R5
    tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |=> stat_q[2]);

    // R3
    phy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(stat_q[5]));

    // R7
    rx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[0]) |-> $past(ev_rx_emptied));

    // R7
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_queued |=> stat_q[0]);

    // R8
    alloc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[3]) |-> $past(ev_alloc_req));

    // R10
    aux_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_aux[3] |=> stat_q[7]);

    // R11
    rdata_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata == (reg_addr ? msk_q : stat_q));

    logic unused_ok;
    assign unused_ok = ev_alloc_done ^ (^ev_aux[2:0]);

endmodule

bind irq_status_unit irq_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .ev_alloc_req  (ev_alloc_req),
    .ev_alloc_done (ev_alloc_done),
    .ev_rx_queued  (ev_rx_queued),
    .ev_rx_emptied (ev_rx_emptied),
    .ev_aux        (ev_aux),
    .tx_count      (tx_count),
    .done_count    (done_count),
    .done_pop      (done_pop),
    .irq           (irq),
    .stat_q        (st_q.status),
    .msk_q         (st_q.mask)
);

// File: tb/irq_status_unit_bench.sv
`timescale 1ns/1ps
module irq_status_unit_bench;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic             reg_addr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             ev_alloc_req = 1'b0;
    logic             ev_alloc_done = 1'b0;
    logic             ev_rx_queued = 1'b0;
    logic             ev_rx_emptied = 1'b0;
    logic [3:0]       ev_aux = '0;
    logic [CNT_W-1:0] tx_count = 3'd1;
    logic [CNT_W-1:0] done_count = '0;
    logic             done_pop;
    logic             irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_status_unit #(.CNT_W(CNT_W)) u_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_alloc_req(ev_alloc_req), .ev_alloc_done(ev_alloc_done),
        .ev_rx_queued(ev_rx_queued), .ev_rx_emptied(ev_rx_emptied),
        .ev_aux(ev_aux), .tx_count(tx_count), .done_count(done_count),
        .done_pop(done_pop), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_stat = 4, m_mask = 0, m_irq = 0;

    function automatic int model_pop();
        return (reg_we && !reg_addr && reg_wdata[1] && done_count != 0) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat <= 4; m_mask <= 0; m_irq <= 0;
        end else begin
            int p, s, mk;
            p  = model_pop();
            s  = m_stat;
            mk = m_mask;
            if (reg_we && !reg_addr) s = s & ~(reg_wdata & 8'hD6);
            if (ev_rx_emptied) s = s & ~1;
            if (ev_alloc_req)  s = s & ~8;
            if (ev_rx_queued)  s = s | 1;
            if (ev_alloc_done) s = s | 8;
            if (tx_count == 0) s = s | 4;
            if (int'(done_count) - p != 0) s = s | 2;
            s = s | (int'(ev_aux) << 4);
            if (reg_we && reg_addr) mk = reg_wdata;
            m_stat <= s & 8'hFF;
            m_mask <= mk;
            m_irq  <= ((s & mk) != 0) ? 1 : 0;
        end
    end

    always begin
        @(posedge clk);
        #1;
        if (rst_n && !finished) begin
            chk("R11 rdata vs model", reg_rdata, reg_addr ? m_mask : m_stat);
            chk("R2 irq vs model", irq, m_irq);
            chk("R4 done_pop vs model", done_pop, model_pop());
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        reg_we = 0; reg_addr = 0; reg_wdata = 0;
        ev_alloc_req = 0; ev_alloc_done = 0; ev_rx_queued = 0;
        ev_rx_emptied = 0; ev_aux = 0;
        #0.5;
    endtask

    task automatic ack(input logic [7:0] v);
        reg_we = 1; reg_addr = 0; reg_wdata = v;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        reg_we = 1; reg_addr = 1; reg_wdata = v;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #0.5;
        // R1 reset state
        chk("R1 status after reset", reg_rdata, 8'h04);
        chk("R1 irq after reset", irq, 0);
        reg_addr = 1; #0.5;
        chk("R1 mask after reset", reg_rdata, 8'h00);
        reg_addr = 0; #0.5;

        // R3 acknowledge clears bit 2
        ack(8'h04); tick();
        chk("R3 ack clears bit2", reg_rdata, 8'h00);

        // R5 empty transmit queue sets bit 2
        tx_count = 0; tick();
        chk("R5 tx empty sets bit2", reg_rdata, 8'h04);
        // R10 set beats acknowledge
        ack(8'h04); tick();
        chk("R10 ack vs tx empty", reg_rdata, 8'h04);
        tx_count = 1; ack(8'h04); tick();
        chk("R3 ack clears bit2 again", reg_rdata, 8'h00);

        // R9 auxiliary causes
        ev_aux = 4'hF; tick();
        chk("R9 aux sets bits 7..4", reg_rdata, 8'hF0);
        ack(8'hFF); tick();
        chk("R3 ack 0xFF keeps bit5", reg_rdata, 8'h20);
        ack(8'h29); tick();
        chk("R3 bits 0,3,5 not clearable", reg_rdata, 8'h20);

        // R7 receive bit
        ev_rx_queued = 1; tick();
        chk("R7 rx queued sets bit0", reg_rdata, 8'h21);
        ack(8'h01); tick();
        chk("R3 ack cannot clear bit0", reg_rdata, 8'h21);
        ev_rx_emptied = 1; tick();
        chk("R7 rx emptied clears bit0", reg_rdata, 8'h20);
        ev_rx_emptied = 1; ev_rx_queued = 1; tick();
        chk("R7 queued wins over emptied", reg_rdata, 8'h21);

        // R8 allocation bit
        ev_alloc_done = 1; tick();
        chk("R8 alloc done sets bit3", reg_rdata, 8'h29);
        ev_alloc_req = 1; tick();
        chk("R8 alloc req clears bit3", reg_rdata, 8'h21);
        ev_alloc_req = 1; ev_alloc_done = 1; tick();
        chk("R8 done wins over req", reg_rdata, 8'h29);

        // R2 mask and irq
        wr_mask(8'h08); tick();
        chk("R2 irq with mask 0x08", irq, 1);
        reg_addr = 1; #0.5;
        chk("R11 mask readback", reg_rdata, 8'h08);
        reg_addr = 0; #0.5;
        wr_mask(8'h02); tick();
        chk("R2 irq with mask 0x02", irq, 0);

        // R4 / R6 completion queue interplay
        done_count = 2; ack(8'h02); #0.5;
        chk("R4 pop strobe with two entries", done_pop, 1);
        tick();
        chk("R6 bit1 survives pop leaving one", reg_rdata, 8'h2B);
        chk("R2 irq on transmit done", irq, 1);
        done_count = 1; ack(8'h02); #0.5;
        chk("R4 pop strobe with one entry", done_pop, 1);
        tick();
        chk("R6 pop of last entry clears bit1", reg_rdata, 8'h29);
        chk("R2 irq drops", irq, 0);
        done_count = 0; ack(8'h02); #0.5;
        chk("R4 no pop on empty queue", done_pop, 0);
        tick();
        done_count = 1; tick();
        chk("R6 nonempty queue sets bit1", reg_rdata, 8'h2B);
        done_count = 0;
        ack(8'h02); #0.5;
        chk("R4 no pop with count zero", done_pop, 0);
        tick();
        chk("R3 ack clears bit1 when queue empty", reg_rdata, 8'h29);

        repeat (4) tick();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule